// File: doc/BRIEF.md
# Vectored Interrupt Address Generator

This block shortens interrupt dispatch for a multi-channel converter. Every channel owns a ready flag that a one-cycle conversion-done strobe sets and that software clears by writing ones to the status register. Instead of scanning the flags, the handler reads the vector register. It returns the stored jump-table base plus the index of the lowest-numbered set flag, shifted left by a programmable amount of 0 to 7. The result is a handler address that can be used directly.

The stored base is never changed by this sum. The addition happens only on the read path, so with no flag set the read returns the written base exactly. Each channel also has an enable bit, and the enable bits are split over two registers. A single interrupt request line is raised while any flag is both set and enabled. The priority selection for the vector uses every set flag, whether it is enabled or not.

Top module: `irq_vector_gen`

## Requirements
- R1: After reset the base, the shift control, all flags and all enables are zero, `irq` is low, `bus_rvalid` is low and `bus_rdata` is zero.
- R2: A read of the vector register (word address 0) with no flag set returns exactly the last value written to address 0, and the stored base is never altered by a read.
- R3: A read of address 0 with at least one flag set returns base + (index << shift), where index is the number of the selected channel. For example, base 0x1234 with shift 2 and channel 2 ready gives 0x123C.
- R4: The selected index is the lowest-numbered set flag, whether or not that channel is enabled. Channel 0 ready with base 0x1234 reads 0x1234.
- R5: The shift control sits at address 1 in bits [2:0]. Writes keep only those bits, and reads return them zero-extended.
- R6: A strobe on `conv_done[i]` sets flag i, and the flags read back at address 2 with flag i in bit i. Writing 1 to bit i of address 2 clears flag i, while bits written as 0 leave their flags unchanged.
- R7: When a strobe and a clear for the same channel occur in the same cycle, the flag ends up set.
- R8: Address 3 holds the enables for channels 0..7 in bits [7:0], and address 4 holds the enables for channels 8..15 in bits [7:0]. `irq` is high exactly when some flag and its enable are both set. It follows the register state with no added delay.
- R9: `bus_rvalid` pulses high in the cycle after `bus_rd_en`, with the read data in `bus_rdata`, which holds its value until the next read. Unmapped addresses read as zero.
- R10: The vector sum wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_done | input | 16 | Per-channel conversion-done strobes |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read strobe |
| irq | output | 1 | Interrupt request, OR of enabled ready flags |

## Verification
A strobe or register write updates the flags and enables on the following edge. Because `irq` is derived from those registers with no extra stage, the bench checks it at the first falling edge after that edge. Read results appear one cycle after the read strobe. The driver therefore queues the value expected from its own flag model at the moment it raises `bus_rd_en`, and the monitor compares that value on the falling edge where `bus_rvalid` is high. All inputs change on falling edges, so the values the bench expects always reflect every edge that has already passed.

// File: rtl/ivg_pkg.sv
package ivg_pkg;
   // Word addresses of the register map
   localparam int unsigned REG_VECTOR = 0;
   localparam int unsigned REG_SHIFT  = 1;
   localparam int unsigned REG_STATUS = 2;
   localparam int unsigned REG_EN_LO  = 3;
   localparam int unsigned REG_EN_HI  = 4;
   localparam int unsigned MAP_WORDS  = 5;
endpackage

// File: rtl/ivg_ready_flags.sv
module ivg_ready_flags #(
   parameter int unsigned NUM_CH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] set_i,
   input  logic [NUM_CH-1:0] clr_i,
   output logic [NUM_CH-1:0] flags_o
);
   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_flag
      logic flag_q;
      always_ff @(posedge clk) begin
         if (!rst_n)          flag_q <= 1'b0;
         else if (set_i[ch])  flag_q <= 1'b1;
         else if (clr_i[ch])  flag_q <= 1'b0;
      end
      assign flags_o[ch] = flag_q;

      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[ch] |=> flags_o[ch]);                        // R7
      AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[ch] && !set_i[ch]) |=> !flags_o[ch]);       // R6
   end
endmodule

// File: rtl/ivg_prio_enc.sv
module ivg_prio_enc #(
   parameter int unsigned NUM_CH   = 16,
   parameter int unsigned IDX_W    = 4,
   parameter int unsigned ENC_ARCH = 0   // 0: descending scan, 1: isolate lowest one
) (
   input  logic [NUM_CH-1:0] req_i,
   output logic [IDX_W-1:0]  idx_o,
   output logic              valid_o
);
   assign valid_o = |req_i;

   if (ENC_ARCH == 0) begin : g_scan
      always_comb begin
         idx_o = '0;
         for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
         end
      end
   end else begin : g_isolate
      logic [NUM_CH-1:0] lowest;
      assign lowest = req_i & (~req_i + NUM_CH'(1));
      always_comb begin
         idx_o = '0;
         for (int b = 0; b < int'(IDX_W); b++) begin
            for (int i = 0; i < int'(NUM_CH); i++) begin
               if (((i >> b) & 1) == 1) idx_o[b] = idx_o[b] | lowest[i];
            end
         end
      end
   end
endmodule

// File: rtl/ivg_vec_adder.sv
module ivg_vec_adder #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned IDX_W   = 4,
   parameter int unsigned SHIFT_W = 3
) (
   input  logic [DATA_W-1:0]  base_i,
   input  logic [IDX_W-1:0]   idx_i,
   input  logic [SHIFT_W-1:0] shift_i,
   output logic [DATA_W-1:0]  vec_o
);
   logic [DATA_W-1:0] offset;
   assign offset = DATA_W'(idx_i) << shift_i;
   assign vec_o  = base_i + offset;   // wraps at DATA_W bits
endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen #(
   parameter int unsigned NUM_CH   = 16,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 3,
   parameter int unsigned SHIFT_W  = 3,
   parameter int unsigned ENC_ARCH = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] conv_done,
   input  logic              bus_wr_en,
   input  logic              bus_rd_en,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_rvalid,
   output logic              irq
);
   import ivg_pkg::*;

   localparam int unsigned IDX_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
   localparam int unsigned EN_LO_W = (NUM_CH + 1) / 2;
   localparam int unsigned EN_HI_W = NUM_CH - EN_LO_W;

   if (NUM_CH < 2 || NUM_CH > DATA_W) begin : g_bad_ch
      $error("irq_vector_gen: NUM_CH must lie in 2..DATA_W");
   end
   if ((1 << ADDR_W) < MAP_WORDS) begin : g_bad_addr
      $error("irq_vector_gen: ADDR_W too small for register map");
   end
   if (SHIFT_W < 1 || SHIFT_W > 5) begin : g_bad_shift
      $error("irq_vector_gen: SHIFT_W must lie in 1..5");
   end

   logic [DATA_W-1:0]  base_q;
   logic [SHIFT_W-1:0] shift_q;
   logic [NUM_CH-1:0]  en_q;
   logic [NUM_CH-1:0]  flags;
   logic [NUM_CH-1:0]  clr;
   logic [IDX_W-1:0]   enc_idx;
   logic               enc_valid;
   logic [DATA_W-1:0]  vec;
   logic [DATA_W-1:0]  rd_mux;
   logic [DATA_W-1:0]  rdata_q;
   logic               rvalid_q;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned r);
      return a == ADDR_W'(r);
   endfunction

   // Configuration registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q  <= '0;
         shift_q <= '0;
         en_q    <= '0;
      end else if (bus_wr_en) begin
         if (hit(bus_addr, REG_VECTOR)) base_q  <= bus_wdata;
         if (hit(bus_addr, REG_SHIFT))  shift_q <= bus_wdata[SHIFT_W-1:0];
         if (hit(bus_addr, REG_EN_LO))  en_q[EN_LO_W-1:0] <= bus_wdata[EN_LO_W-1:0];
         if (hit(bus_addr, REG_EN_HI))  en_q[NUM_CH-1:EN_LO_W] <= bus_wdata[EN_HI_W-1:0];
      end
   end

   assign clr = (bus_wr_en && hit(bus_addr, REG_STATUS)) ? bus_wdata[NUM_CH-1:0] : '0;

   ivg_ready_flags #(.NUM_CH(NUM_CH)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (conv_done),
      .clr_i   (clr),
      .flags_o (flags)
   );

   ivg_prio_enc #(.NUM_CH(NUM_CH), .IDX_W(IDX_W), .ENC_ARCH(ENC_ARCH)) u_enc (
      .req_i   (flags),
      .idx_o   (enc_idx),
      .valid_o (enc_valid)
   );

   ivg_vec_adder #(.DATA_W(DATA_W), .IDX_W(IDX_W), .SHIFT_W(SHIFT_W)) u_add (
      .base_i  (base_q),
      .idx_i   (enc_idx),
      .shift_i (shift_q),
      .vec_o   (vec)
   );

   // Read path: summed vector computed at read time, registered once
   always_comb begin
      rd_mux = '0;
      if (hit(bus_addr, REG_VECTOR)) rd_mux = vec;
      if (hit(bus_addr, REG_SHIFT))  rd_mux = DATA_W'(shift_q);
      if (hit(bus_addr, REG_STATUS)) rd_mux = DATA_W'(flags);
      if (hit(bus_addr, REG_EN_LO))  rd_mux = DATA_W'(en_q[EN_LO_W-1:0]);
      if (hit(bus_addr, REG_EN_HI))  rd_mux = DATA_W'(en_q[NUM_CH-1:EN_LO_W]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
      end else begin
         rvalid_q <= bus_rd_en;
         if (bus_rd_en) rdata_q <= rd_mux;
      end
   end

   assign bus_rdata  = rdata_q;
   assign bus_rvalid = rvalid_q;
   assign irq        = |(flags & en_q);

   AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd_en |=> bus_rvalid);                                     // R9
   AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_rd_en) |-> $stable(bus_rdata));                     // R9
   AST_EMPTY_PASSES_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      !enc_valid |-> (vec == base_q));                               // R2
   AST_ENC_PICKS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      enc_valid |-> flags[enc_idx]);                                 // R4
   AST_ENC_NONE_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
      enc_valid |-> ((flags & ((NUM_CH'(1) << enc_idx) - NUM_CH'(1))) == '0)); // R4
   AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (|en_q));                                              // R8
endmodule

// File: tb/irq_vector_gen_tb.sv
module irq_vector_gen_tb_top;
   localparam int unsigned NUM_CH = 16;
   localparam int unsigned DATA_W = 32;
   localparam int unsigned ADDR_W = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NUM_CH-1:0] conv_done = '0;
   logic              bus_wr_en = 1'b0;
   logic              bus_rd_en = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic [DATA_W-1:0] bus_rdata;
   logic              bus_rvalid;
   logic              irq;

   int n_chk = 0;
   int n_err = 0;
   logic [DATA_W-1:0] exp_q[$];
   string             tag_q[$];

   // 20 ns period (50 MHz) with 1 ns time units
   always #10 clk = ~clk;

   irq_vector_gen dut_i (
      .clk(clk), .rst_n(rst_n), .conv_done(conv_done),
      .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
      .irq(irq)
   );

   task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   // Expected vector from the requirement: base + (lowest set index << shift)
   function automatic logic [DATA_W-1:0] exp_vec(input logic [DATA_W-1:0] base,
                                                 input int sh, input logic [NUM_CH-1:0] fl);
      for (int i = 0; i < int'(NUM_CH); i++)
         if (fl[i]) return base + (DATA_W'(i) << sh);
      return base;
   endfunction

   task automatic wr(input int a, input logic [DATA_W-1:0] d);
      @(negedge clk);
      bus_wr_en = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
      @(negedge clk);
      bus_wr_en = 1'b0;
   endtask

   task automatic strobe(input logic [NUM_CH-1:0] m);
      @(negedge clk);
      conv_done = m;
      @(negedge clk);
      conv_done = '0;
   endtask

   task automatic wr_with_strobe(input int a, input logic [DATA_W-1:0] d, input logic [NUM_CH-1:0] m);
      @(negedge clk);
      bus_wr_en = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d; conv_done = m;
      @(negedge clk);
      bus_wr_en = 1'b0; conv_done = '0;
   endtask

   // Driver: issue a read and queue the expected result
   task automatic rd(input int a, input logic [DATA_W-1:0] e, input string tag);
      @(negedge clk);
      bus_rd_en = 1'b1; bus_addr = ADDR_W'(a);
      exp_q.push_back(e); tag_q.push_back(tag);
      @(negedge clk);
      bus_rd_en = 1'b0;
   endtask

   // Monitor: compare each returned word with the queued expectation
   always @(negedge clk) begin
      if (rst_n && bus_rvalid) begin
         if (exp_q.size() == 0) chk("R9 unexpected rvalid", 32'd1, 32'd0);
         else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
   end

   initial begin
      #(20 * 100000);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 irq after reset", DATA_W'(irq), 0);
      chk("R1 rvalid after reset", DATA_W'(bus_rvalid), 0);
      chk("R1 rdata after reset", bus_rdata, 0);
      rd(0, 0, "R1 base reset");
      rd(1, 0, "R1 shift reset");
      rd(2, 0, "R1 status reset");
      rd(3, 0, "R1 enable lo reset");
      rd(4, 0, "R1 enable hi reset");

      // R2 / R5 base and shift
      wr(0, 32'h1234);
      wr(1, 2);
      rd(0, 32'h1234, "R2 base no flags");
      rd(1, 2, "R5 shift readback");

      // R3 / R6 channel 2 ready
      strobe(16'h0004);
      rd(2, 32'h4, "R6 status after strobe");
      rd(0, 32'h123C, "R3 example ch2");
      chk("R8 irq low while disabled", DATA_W'(irq), 0);

      // R4 channel 0 also ready, wins
      strobe(16'h0001);
      rd(0, 32'h1234, "R4 ch0 highest priority");
      rd(2, 32'h5, "R6 status two flags");

      // R8 enable channel 2 only (ch0 stays disabled but still wins vector)
      wr(3, 32'h4);
      chk("R8 irq with ch2 enabled", DATA_W'(irq), 1);
      rd(0, 32'h1234, "R4 disabled flag still selects");
      wr(2, 32'h5);
      chk("R8 irq after clear", DATA_W'(irq), 0);
      rd(2, 0, "R6 write-1 clear");

      // R3 larger shift, high channels
      wr(1, 7);
      strobe(16'h2200);
      rd(0, exp_vec(32'h1234, 7, 16'h2200), "R3 ch9 shift7");
      chk("R8 irq with hi disabled", DATA_W'(irq), 0);
      wr(4, 32'h20);
      chk("R8 irq ch13 enabled via hi reg", DATA_W'(irq), 1);
      rd(4, 32'h20, "R8 enable hi readback");
      rd(3, 32'h4, "R8 enable lo readback");
      wr(2, 32'h200);
      rd(0, 32'h18B4, "R3 ch13 shift7");
      wr(2, 32'h0);
      rd(2, 32'h2000, "R6 zero write no effect");

      // R7 set beats clear on the same channel; clear of other channel works
      wr_with_strobe(2, 32'h2000, 16'h2000);
      rd(2, 32'h2000, "R7 set wins");
      wr_with_strobe(2, 32'h2000, 16'h0002);
      rd(2, 32'h2, "R6 clear with other strobe");
      rd(0, 32'h12B4, "R3 ch1 shift7");

      // R10 wrap
      wr(0, 32'hFFFF_FFF0);
      wr(1, 3);
      strobe(16'h2000);
      rd(0, 32'hFFFF_FFF8, "R10 ch1 shift3 no wrap");
      wr(2, 32'h2);
      rd(0, 32'h0000_0058, "R10 wrap ch13 shift3");
      wr(1, 32'hFFFF_FFFF);
      rd(1, 7, "R5 only low bits kept");
      rd(0, 32'h0000_0670, "R10 wrap ch13 shift7");

      // R2 stored base unaltered after vector reads
      wr(2, 32'hFFFF);
      rd(0, 32'hFFFF_FFF0, "R2 base unaltered");
      chk("R8 irq all clear", DATA_W'(irq), 0);

      // R9 unmapped address, idle rvalid
      rd(7, 0, "R9 unmapped reads zero");
      @(negedge clk);
      chk("R9 rvalid idle", DATA_W'(bus_rvalid), 0);
      chk("R9 rdata held", bus_rdata, 0);

      // R8 irq follows a strobe on an enabled channel at once
      strobe(16'h0004);
      chk("R8 irq after enabled strobe", DATA_W'(irq), 1);

      repeat (2) @(negedge clk);
      chk("R9 all reads answered", DATA_W'(exp_q.size()), 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule